// File: doc/BRIEF.md
# System Clock Ratio Divider Bank

This block turns one fast source clock into three rate-reduced clock enables: a core enable, a bus enable and a peripheral enable. Rather than creating new clocks, every output is a pulse that is high for a single source cycle. Downstream logic running on the same source clock uses these pulses to qualify its registers. The pace is set by two qualifying strobes that arrive in the source domain, one at crystal rate and one at PLL rate. A bit in the configuration word chooses which of the two drives the bank.

A 32-bit configuration word selects the ratios from fixed lookup tables. These tables include non-power-of-two divisors and aliased codes. The peripheral enable does not count source strobes. It counts bus pulses, so its rate is the bus rate divided once more. The same word also holds the PLL multiply and divide fields, and the block reports the resulting factors so that the programmed frequency can be seen.

A new configuration word is sampled and applied only on a strobe cycle in which all three enables pulse together. Because of this, no pulse period is ever cut short or stretched when the ratios change.

Top module: `clkr_ratio_bank`

## Requirements
- R1: Every enable output is high only in a cycle where the selected source strobe is high. A divisor of N gives exactly one pulse per N selected strobes, and N=1 gives a pulse on every selected strobe.
- R2: The core ratio code is cfg_word[27:25]. Codes 0..7 give divisors 1, 2, 4, 8, 16, 1, 1, 1.
- R3: The bus ratio code is cfg_word[22:20]. Codes 0..7 give divisors 1, 2, 4, 5, 6, 8, 16, 32.
- R4: The peripheral ratio code is cfg_word[19:18]. Codes 0..3 give divisors 1, 2, 4, 8, and the divisor counts bus pulses. per_en is never high without bus_en.
- R5: cfg_word[23] set to 1 selects pll_stb as the source strobe, and 0 selects xtal_stb. src_is_pll reports the applied choice.
- R6: pll_mul equals (cfg[15:11]+1)*(cfg[10:5]+1), pll_idiv equals cfg[4:0]+1, and pll_shift equals cfg[17:16], all taken from the applied word.
- R7: cfg_word is sampled only at the clock edge that ends a cycle in which the selected strobe is high and core_en, bus_en and per_en are all high. At every other edge the applied configuration is held.
- R8: While rst is high at a clock edge, all counters clear and every ratio becomes 1. xtal_stb is selected, pll_mul and pll_idiv become 1, and pll_shift becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 32 | Ratio, source select and PLL field word |
| xtal_stb | input | 1 | Crystal-rate qualifying strobe |
| pll_stb | input | 1 | PLL-rate qualifying strobe |
| core_en | output | 1 | Core clock enable pulse |
| bus_en | output | 1 | Bus clock enable pulse |
| per_en | output | 1 | Peripheral clock enable pulse |
| src_is_pll | output | 1 | Applied source selection |
| pll_mul | output | 12 | PLL multiply factor |
| pll_idiv | output | 6 | PLL input divide factor |
| pll_shift | output | 2 | PLL post-scaler shift |

## Verification
Random configuration words are applied while both strobes toggle at random. This mixes all table codes, both sources and gaps in the strobes. A cycle-accurate model then separates a correct divisor table from a wrong one, and a correct apply point from a late or early one. Directed runs with steady strobes count pulses for the divide-by-5 bus code and the aliased core code 6. These counts show whether a table entry itself is wrong or whether the pulse phase is wrong. A run that holds the crystal strobe low while the PLL strobe runs, and then the reverse, shows whether the bypass bit actually steers the source.

// File: rtl/clkr_pkg.sv
package clkr_pkg;

    localparam int CFG_W   = 32;
    localparam int RATIO_W = 6;
    localparam int MUL_W   = 12;
    localparam int IDIV_W  = 6;

    typedef enum logic {
        SRC_XTAL = 1'b0,
        SRC_PLL  = 1'b1
    } src_sel_e;

    typedef struct packed {
        src_sel_e   src;
        logic [2:0] core_code;
        logic [2:0] bus_code;
        logic [1:0] per_code;
        logic [1:0] ps;
        logic [4:0] fb1;
        logic [5:0] fb2;
        logic [4:0] ipd;
    } ratio_cfg_t;

    localparam ratio_cfg_t RATIO_RESET = '{
        src: SRC_XTAL, core_code: 3'd0, bus_code: 3'd0, per_code: 2'd0,
        ps: 2'd0, fb1: 5'd0, fb2: 6'd0, ipd: 5'd0
    };

    function automatic ratio_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
        ratio_cfg_t c;
        c.src       = w[23] ? SRC_PLL : SRC_XTAL;
        c.core_code = w[27:25];
        c.bus_code  = w[22:20];
        c.per_code  = w[19:18];
        c.ps        = w[17:16];
        c.fb1       = w[15:11];
        c.fb2       = w[10:5];
        c.ipd       = w[4:0];
        return c;
    endfunction

    function automatic logic [RATIO_W-1:0] core_ratio(input logic [2:0] code);
        case (code)
            3'd1:    return RATIO_W'(2);
            3'd2:    return RATIO_W'(4);
            3'd3:    return RATIO_W'(8);
            3'd4:    return RATIO_W'(16);
            default: return RATIO_W'(1);
        endcase
    endfunction

    function automatic logic [RATIO_W-1:0] bus_ratio(input logic [2:0] code);
        case (code)
            3'd0:    return RATIO_W'(1);
            3'd1:    return RATIO_W'(2);
            3'd2:    return RATIO_W'(4);
            3'd3:    return RATIO_W'(5);
            3'd4:    return RATIO_W'(6);
            3'd5:    return RATIO_W'(8);
            3'd6:    return RATIO_W'(16);
            default: return RATIO_W'(32);
        endcase
    endfunction

    function automatic logic [RATIO_W-1:0] per_ratio(input logic [1:0] code);
        return RATIO_W'(1) << code;
    endfunction

endpackage

// File: rtl/clkr_ratio_counter.sv
module clkr_ratio_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic [W-1:0] ratio,
    output logic         at_end
);
    logic [W-1:0] cnt_q;

    assign at_end = (cnt_q == ratio - W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= at_end ? '0 : cnt_q + W'(1);
        end
    end
endmodule

// File: rtl/clkr_pll_factor.sv
module clkr_pll_factor
    import clkr_pkg::*;
(
    input  ratio_cfg_t         cfg,
    output logic [MUL_W-1:0]   mul,
    output logic [IDIV_W-1:0]  idiv,
    output logic [1:0]         shift
);
    logic [MUL_W-1:0] f1;
    logic [MUL_W-1:0] f2;

    always_comb begin
        f1    = MUL_W'(cfg.fb1) + MUL_W'(1);
        f2    = MUL_W'(cfg.fb2) + MUL_W'(1);
        mul   = f1 * f2;
        idiv  = IDIV_W'(cfg.ipd) + IDIV_W'(1);
        shift = cfg.ps;
    end
endmodule

// File: rtl/clkr_ratio_bank.sv
module clkr_ratio_bank
    import clkr_pkg::*;
#(
    parameter int CNT_W = RATIO_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CFG_W-1:0]    cfg_word,
    input  logic                xtal_stb,
    input  logic                pll_stb,
    output logic                core_en,
    output logic                bus_en,
    output logic                per_en,
    output logic                src_is_pll,
    output logic [MUL_W-1:0]    pll_mul,
    output logic [IDIV_W-1:0]   pll_idiv,
    output logic [1:0]          pll_shift
);
    localparam int NSRC = 2;

    ratio_cfg_t act_q;
    logic       base_stb;
    logic       boundary;
    logic       per_end;

    logic [NSRC-1:0]       src_end;
    logic [CNT_W-1:0]      src_ratio [NSRC];

    assign base_stb     = (act_q.src == SRC_PLL) ? pll_stb : xtal_stb;
    assign src_ratio[0] = CNT_W'(core_ratio(act_q.core_code));
    assign src_ratio[1] = CNT_W'(bus_ratio(act_q.bus_code));

    // Source-paced counters: index 0 = core, index 1 = bus
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        clkr_ratio_counter #(.W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst    (rst),
            .step   (base_stb),
            .ratio  (src_ratio[g]),
            .at_end (src_end[g])
        );
    end

    assign core_en = base_stb & src_end[0];
    assign bus_en  = base_stb & src_end[1];

    clkr_ratio_counter #(.W(CNT_W)) u_per_cnt (
        .clk    (clk),
        .rst    (rst),
        .step   (bus_en),
        .ratio  (CNT_W'(per_ratio(act_q.per_code))),
        .at_end (per_end)
    );

    assign per_en   = bus_en & per_end;
    assign boundary = core_en & per_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= RATIO_RESET;
        end else if (boundary) begin
            act_q <= decode_cfg(cfg_word);
        end
    end

    assign src_is_pll = (act_q.src == SRC_PLL);

    clkr_pll_factor u_pll_factor (
        .cfg   (act_q),
        .mul   (pll_mul),
        .idiv  (pll_idiv),
        .shift (pll_shift)
    );
endmodule

// File: rtl/clkr_ratio_bank_chk.sv
module clkr_ratio_bank_chk
    import clkr_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [CFG_W-1:0]    cfg_word,
    input logic                xtal_stb,
    input logic                pll_stb,
    input logic                core_en,
    input logic                bus_en,
    input logic                per_en,
    input logic                src_is_pll,
    input logic [MUL_W-1:0]    pll_mul,
    input logic [IDIV_W-1:0]   pll_idiv,
    input logic [1:0]          pll_shift
);
    // R1
    core_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        core_en |-> (src_is_pll ? pll_stb : xtal_stb));

    // R1
    bus_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        bus_en |-> (src_is_pll ? pll_stb : xtal_stb));

    // R4
    per_within_bus_chk: assert property (@(posedge clk) disable iff (rst)
        per_en |-> bus_en);

    // R7
    hold_off_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        !(core_en && bus_en && per_en) |=>
            ($stable(src_is_pll) && $stable(pll_mul) && $stable(pll_idiv) && $stable(pll_shift)));

    // R8
    reset_defaults_chk: assert property (@(posedge clk)
        rst |=> (!src_is_pll && pll_mul == MUL_W'(1) && pll_idiv == IDIV_W'(1) && pll_shift == 2'd0));
endmodule

bind clkr_ratio_bank clkr_ratio_bank_chk u_chk (.*);

// File: tb/test_clkr_ratio_bank.sv
`timescale 1ns/1ps
module test_clkr_ratio_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_word = '0;
    logic        xtal_stb = 1'b0;
    logic        pll_stb = 1'b0;
    logic        core_en, bus_en, per_en, src_is_pll;
    logic [11:0] pll_mul;
    logic [5:0]  pll_idiv;
    logic [1:0]  pll_shift;

    int n_chk = 0;
    int n_fail = 0;
    int n_core = 0;
    int n_bus = 0;
    bit done = 0;

    // reference state
    int          m_core, m_bus, m_per;
    logic [31:0] m_cfg;

    always #2 clk = ~clk;

    clkr_ratio_bank i_clkr_ratio_bank (
        .clk(clk), .rst(rst), .cfg_word(cfg_word), .xtal_stb(xtal_stb), .pll_stb(pll_stb),
        .core_en(core_en), .bus_en(bus_en), .per_en(per_en), .src_is_pll(src_is_pll),
        .pll_mul(pll_mul), .pll_idiv(pll_idiv), .pll_shift(pll_shift)
    );

    function automatic int t_core(input logic [2:0] c);
        int tab [8] = '{1, 2, 4, 8, 16, 1, 1, 1};
        return tab[c];
    endfunction
    function automatic int t_bus(input logic [2:0] c);
        int tab [8] = '{1, 2, 4, 5, 6, 8, 16, 32};
        return tab[c];
    endfunction
    function automatic int t_per(input logic [1:0] c);
        int tab [4] = '{1, 2, 4, 8};
        return tab[c];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic r, input logic xs, input logic ps, input logic [31:0] cw);
        logic base, ce, be, pe, bnd;
        int   cd, bd, pd;
        @(negedge clk);
        rst = r; xtal_stb = xs; pll_stb = ps; cfg_word = cw;
        #1;
        if (r) begin
            m_core = 0; m_bus = 0; m_per = 0; m_cfg = '0;
            return;
        end
        base = m_cfg[23] ? ps : xs;
        cd = t_core(m_cfg[27:25]);
        bd = t_bus(m_cfg[22:20]);
        pd = t_per(m_cfg[19:18]);
        ce = base && (m_core == cd - 1);
        be = base && (m_bus == bd - 1);
        pe = be && (m_per == pd - 1);
        bnd = ce && pe;
        chk(core_en === ce, "R1 R2 core_en", int'(core_en), int'(ce));
        chk(bus_en === be, "R1 R3 bus_en", int'(bus_en), int'(be));
        chk(per_en === pe, "R4 per_en", int'(per_en), int'(pe));
        chk(src_is_pll === m_cfg[23], "R5 R7 src_is_pll", int'(src_is_pll), int'(m_cfg[23]));
        chk(pll_mul == 12'((m_cfg[15:11] + 1) * (m_cfg[10:5] + 1)), "R6 R7 pll_mul",
            int'(pll_mul), (int'(m_cfg[15:11]) + 1) * (int'(m_cfg[10:5]) + 1));
        chk(pll_idiv == 6'(m_cfg[4:0] + 1) && pll_shift == m_cfg[17:16], "R6 R7 idiv/shift",
            int'({pll_idiv, pll_shift}), int'({6'(m_cfg[4:0] + 1), m_cfg[17:16]}));
        if (core_en) n_core++;
        if (bus_en) n_bus++;
        if (base) begin
            m_core = (m_core == cd - 1) ? 0 : m_core + 1;
            m_bus  = (m_bus == bd - 1) ? 0 : m_bus + 1;
        end
        if (be) m_per = (m_per == pd - 1) ? 0 : m_per + 1;
        if (bnd) m_cfg = cw;
    endtask

    task automatic do_reset();
        cyc(1'b1, 1'b0, 1'b0, '0);
        cyc(1'b1, 1'b0, 1'b0, '0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        void'($urandom(32'd7341));

        // R8: reset state
        do_reset();
        @(negedge clk); #1;
        n_chk++;
        if (src_is_pll !== 1'b0 || pll_mul !== 12'd1 || pll_idiv !== 6'd1 || pll_shift !== 2'd0) begin
            n_fail++;
            $display("FAIL R8 reset state actual=%0d expected=%0d",
                     int'({src_is_pll, pll_mul, pll_idiv, pll_shift}), int'({1'b0, 12'd1, 6'd1, 2'd0}));
        end

        // R3: divide-by-5 bus, 10 pulses in 50 strobes
        do_reset();
        cyc(1'b0, 1'b1, 1'b1, 32'h0030_0000);
        n_bus = 0;
        for (int i = 0; i < 50; i++) cyc(1'b0, 1'b1, 1'b1, 32'h0030_0000);
        chk(n_bus == 10, "R3 divide-by-5 pulse count", n_bus, 10);

        // R2: aliased core code 6 acts as divide-by-1
        do_reset();
        cyc(1'b0, 1'b1, 1'b1, 32'h0C00_0000);
        n_core = 0;
        for (int i = 0; i < 20; i++) cyc(1'b0, 1'b1, 1'b1, 32'h0C00_0000);
        chk(n_core == 20, "R2 alias code 6 pulse count", n_core, 20);

        // R5: bypass bit steers the source
        do_reset();
        cyc(1'b0, 1'b1, 1'b0, 32'h0080_0000);
        n_core = 0;
        for (int i = 0; i < 10; i++) cyc(1'b0, 1'b0, 1'b1, 32'h0080_0000);
        chk(n_core == 10, "R5 pll strobe drives pulses", n_core, 10);
        n_core = 0;
        for (int i = 0; i < 10; i++) cyc(1'b0, 1'b1, 1'b0, 32'h0080_0000);
        chk(n_core == 0, "R5 crystal strobe ignored", n_core, 0);

        // R7 R1: random mix
        do_reset();
        w = $urandom();
        for (int i = 0; i < 20000; i++) begin
            if ($urandom_range(0, 299) == 0) w = $urandom();
            cyc(1'b0, ($urandom_range(0, 3) != 0), ($urandom_range(0, 3) != 0), w);
            if ($urandom_range(0, 4999) == 0) do_reset();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule